// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Responder

This block is the slave end of a single-wire, open-drain, pulled-up bus. It measures every low pulse the master drives on the line. When a pulse qualifies as a reset, the block answers with a presence pulse. It also decides the link speed: standard or overdrive. Time is measured in ticks of a one-microsecond strobe (`tick_us`). The block pulls the line low only for the presence pulse. Any other falling edge comes from the master.

The length of the reset pulse sets the speed that follows it:

- A long reset always returns the link to standard speed.
- A short reset received in overdrive keeps overdrive.
- A reset in overdrive whose length falls between those two bands leaves the speed undetermined. The block then falls back to standard speed and raises `speed_unknown`. The flag stays up until the next valid reset.

Higher-level command logic requests overdrive with `od_req`. Once the presence sequence and its recovery time are over, the block emits `slot_ready` for one cycle, so the bit-slot engine may begin.

Top module: `owr_responder`

## Requirements
- R1: After reset `pull_low`, `od_mode`, `speed_unknown` and `slot_ready` are all 0, meaning standard speed and a released line.
- R2: A low pulse of 480 or more ticks is a reset at either speed. It sets `od_mode`=0 and `speed_unknown`=0.
- R3: In overdrive (`od_mode`=1), a low pulse of 48 to 80 ticks inclusive is a reset. It keeps `od_mode`=1 and clears `speed_unknown`.
- R4: In overdrive, a low pulse of 81 to 479 ticks is a reset. It sets `od_mode`=0 and `speed_unknown`=1. The flag changes only on a later valid reset.
- R5: A low pulse that is not a reset has no effect on any output. At standard speed that is any pulse under 480 ticks; in overdrive, any pulse under 48 ticks.
- R6: After a reset, the block waits a delay once the line reads high, then holds `pull_low`=1 for a fixed time. Delay and width depend on the speed that results from the reset: 30 and 120 ticks at standard speed, 3 and 12 ticks in overdrive.
- R7: `pull_low` is 1 only during a presence pulse. The block never drives the line while idle.
- R8: After the presence pulse ends and a recovery time passes (5 ticks at standard speed, 2 in overdrive), `slot_ready` is high for exactly one clock.
- R9: If the line is seen low while the block is waiting to send presence, the presence pulse is cancelled. The low time is then measured afresh as a new pulse.
- R10: A one-cycle `od_req` while idle sets `od_mode`=1 and leaves `speed_unknown` unchanged. An `od_req` during the reset/presence sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-clock strobe marking each microsecond |
| bus_in | input | 1 | Raw bus level, synchronized inside by two flops |
| od_req | input | 1 | Command logic request to enter overdrive |
| pull_low | output | 1 | Open-drain pull-down enable (1 drives the line low) |
| od_mode | output | 1 | Current speed: 1 overdrive, 0 standard |
| speed_unknown | output | 1 | Last reset fell in the undetermined band |
| slot_ready | output | 1 | One-cycle pulse: bit slots may start |

## Verification
The properties assume the following about the inputs:

- `tick_us` is a single-clock strobe with several clocks between strobes.
- `bus_in` may change at any time, because it passes through the synchronizer.
- `od_req` is a one-clock pulse.
- The master never drives the line while the block sends presence.

The stimulus keeps within these limits. It raises the tick every fourth clock. It starts and ends each master low pulse right after a tick, so the pulse length in ticks is exact. It fires `od_req` either while idle or deliberately in the middle of a sequence. A behavioural model in the bench predicts every output on every clock. Directed checks cover the band edges at 47, 48, 80, 81, 479 and 480 ticks.

// File: rtl/owr_pkg.sv
package owr_pkg;

  typedef enum logic [1:0] {
    RK_NONE    = 2'd0,
    RK_KEEP_OD = 2'd1,
    RK_UNDET   = 2'd2,
    RK_STD     = 2'd3
  } rst_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_PRES = 2'd2,
    SQ_REC  = 2'd3
  } seq_st_e;

  // Classify a finished low pulse of len ticks at the current speed.
  function automatic rst_kind_e classify_low(
    input int unsigned len,
    input logic        od,
    input int unsigned std_min,
    input int unsigned od_max,
    input int unsigned od_min
  );
    rst_kind_e k;
    if (len >= std_min)              k = RK_STD;
    else if (od && (len > od_max))   k = RK_UNDET;
    else if (od && (len >= od_min))  k = RK_KEEP_OD;
    else                             k = RK_NONE;
    return k;
  endfunction

  // Select a phase length for the active speed.
  function automatic int unsigned phase_len(
    input logic        od,
    input int unsigned std_v,
    input int unsigned od_v
  );
    return od ? od_v : std_v;
  endfunction

endpackage

// File: rtl/owr_sync.sv
module owr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic line,
  output logic rise
);
  logic s1, s2, line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      line_d <= 1'b1;
    end else begin
      s1     <= bus_in;
      s2     <= s1;
      line_d <= s2;
    end
  end

  assign line = s2;
  assign rise = s2 & ~line_d;
endmodule

// File: rtl/owr_meter.sv
module owr_meter
  import owr_pkg::*;
#(
  parameter int unsigned CW            = 10,
  parameter int unsigned STD_RST_US    = 480,
  parameter int unsigned OD_RST_MAX_US = 80,
  parameter int unsigned OD_RST_MIN_US = 48
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      line,
  input  logic      rise,
  input  logic      tick,
  input  logic      od,
  output rst_kind_e kind
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (!en || rise)
      low_cnt <= '0;
    else if (!line && tick && (low_cnt != {CW{1'b1}}))
      low_cnt <= low_cnt + CW'(1);
  end

  always_comb begin
    if (rise)
      kind = classify_low(32'(low_cnt), od, STD_RST_US, OD_RST_MAX_US, OD_RST_MIN_US);
    else
      kind = RK_NONE;
  end
endmodule

// File: rtl/owr_seq.sv
module owr_seq
  import owr_pkg::*;
#(
  parameter int unsigned TW      = 7,
  parameter int unsigned STD_PDH = 30,
  parameter int unsigned STD_PDL = 120,
  parameter int unsigned STD_REC = 5,
  parameter int unsigned OD_PDH  = 3,
  parameter int unsigned OD_PDL  = 12,
  parameter int unsigned OD_REC  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line,
  input  rst_kind_e kind,
  input  logic      od_req,
  output logic      pull_low,
  output logic      od_mode,
  output logic      speed_unknown,
  output logic      slot_ready,
  output logic      idle,
  output logic      rst_evt
);
  seq_st_e       st;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] last_cnt;
  logic          phase_done;

  assign idle    = (st == SQ_IDLE);
  assign rst_evt = idle && (kind != RK_NONE);

  always_comb begin
    unique case (st)
      SQ_WAIT: last_cnt = TW'(phase_len(od_mode, STD_PDH, OD_PDH) - 1);
      SQ_PRES: last_cnt = TW'(phase_len(od_mode, STD_PDL, OD_PDL) - 1);
      SQ_REC:  last_cnt = TW'(phase_len(od_mode, STD_REC, OD_REC) - 1);
      default: last_cnt = '0;
    endcase
  end

  assign phase_done = tick && (tcnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= SQ_IDLE;
      tcnt          <= '0;
      od_mode       <= 1'b0;
      speed_unknown <= 1'b0;
      slot_ready    <= 1'b0;
    end else begin
      slot_ready <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          tcnt <= '0;
          if (rst_evt) begin
            st <= SQ_WAIT;
            unique case (kind)
              RK_STD:     begin od_mode <= 1'b0; speed_unknown <= 1'b0; end
              RK_UNDET:   begin od_mode <= 1'b0; speed_unknown <= 1'b1; end
              RK_KEEP_OD: begin speed_unknown <= 1'b0; end
              default:    ;
            endcase
          end else if (od_req) begin
            od_mode <= 1'b1;
          end
        end
        SQ_WAIT: begin
          if (!line) begin
            st   <= SQ_IDLE;
            tcnt <= '0;
          end else if (phase_done) begin
            st   <= SQ_PRES;
            tcnt <= '0;
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        SQ_PRES: begin
          if (phase_done) begin
            st   <= SQ_REC;
            tcnt <= '0;
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        SQ_REC: begin
          if (phase_done) begin
            st         <= SQ_IDLE;
            tcnt       <= '0;
            slot_ready <= 1'b1;
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign pull_low = (st == SQ_PRES);
endmodule

// File: rtl/owr_responder.sv
module owr_responder
  import owr_pkg::*;
#(
  parameter int unsigned STD_RST_US    = 480,
  parameter int unsigned OD_RST_MAX_US = 80,
  parameter int unsigned OD_RST_MIN_US = 48,
  parameter int unsigned STD_PDH       = 30,
  parameter int unsigned STD_PDL       = 120,
  parameter int unsigned STD_REC       = 5,
  parameter int unsigned OD_PDH        = 3,
  parameter int unsigned OD_PDL        = 12,
  parameter int unsigned OD_REC        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic bus_in,
  input  logic od_req,
  output logic pull_low,
  output logic od_mode,
  output logic speed_unknown,
  output logic slot_ready
);
  localparam int unsigned CW    = $clog2(STD_RST_US + 1) + 1;
  localparam int unsigned TMAX1 = (STD_PDH > STD_PDL) ? STD_PDH : STD_PDL;
  localparam int unsigned TMAX  = (TMAX1 > STD_REC) ? TMAX1 : STD_REC;
  localparam int unsigned TW    = $clog2(TMAX + 1);

  logic      line;
  logic      rise;
  logic      idle;
  logic      rst_evt;
  rst_kind_e rst_kind;

  owr_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in (bus_in),
    .line   (line),
    .rise   (rise)
  );

  owr_meter #(
    .CW            (CW),
    .STD_RST_US    (STD_RST_US),
    .OD_RST_MAX_US (OD_RST_MAX_US),
    .OD_RST_MIN_US (OD_RST_MIN_US)
  ) u_meter (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (idle),
    .line  (line),
    .rise  (rise),
    .tick  (tick_us),
    .od    (od_mode),
    .kind  (rst_kind)
  );

  owr_seq #(
    .TW      (TW),
    .STD_PDH (STD_PDH),
    .STD_PDL (STD_PDL),
    .STD_REC (STD_REC),
    .OD_PDH  (OD_PDH),
    .OD_PDL  (OD_PDL),
    .OD_REC  (OD_REC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick_us),
    .line          (line),
    .kind          (rst_kind),
    .od_req        (od_req),
    .pull_low      (pull_low),
    .od_mode       (od_mode),
    .speed_unknown (speed_unknown),
    .slot_ready    (slot_ready),
    .idle          (idle),
    .rst_evt       (rst_evt)
  );
endmodule

// File: rtl/owr_checker.sv
module owr_checker
  import owr_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      pull_low,
  input logic      od_mode,
  input logic      speed_unknown,
  input logic      slot_ready,
  input logic      idle,
  input logic      rst_evt,
  input rst_kind_e rst_kind
);
  p_long_reset_std_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && rst_kind == RK_STD) |=> (!od_mode && !speed_unknown));

  p_short_keeps_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && rst_kind == RK_KEEP_OD) |=> (od_mode && !speed_unknown));

  p_keep_needs_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && rst_kind == RK_KEEP_OD) |-> od_mode);

  p_mid_band_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && rst_kind == RK_UNDET) |=> (!od_mode && speed_unknown));

  p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_evt) |=> $stable(speed_unknown));

  p_no_drive_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !pull_low);

  p_ready_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ready |=> !slot_ready);

  p_speed_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> $stable(od_mode));
endmodule

bind owr_responder owr_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pull_low      (pull_low),
  .od_mode       (od_mode),
  .speed_unknown (speed_unknown),
  .slot_ready    (slot_ready),
  .idle          (idle),
  .rst_evt       (rst_evt),
  .rst_kind      (rst_kind)
);

// File: tb/test_owr_responder.sv
`timescale 1ns/1ps
module test_owr_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic m_low = 1'b0;
  logic od_req = 1'b0;
  logic pull_low, od_mode, speed_unknown, slot_ready;
  logic bus;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit model_on = 1'b0;
  bit watch = 1'b0;
  int watch_pulls = 0;

  always #4 clk = ~clk;

  assign bus = ~(m_low | pull_low);

  owr_responder i_owr_responder (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_us       (tick_us),
    .bus_in        (bus),
    .od_req        (od_req),
    .pull_low      (pull_low),
    .od_mode       (od_mode),
    .speed_unknown (speed_unknown),
    .slot_ready    (slot_ready)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_us <= ((cyc % 4) == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit h1 = 1, h2 = 1, hprev = 1;
  int ph = 0, tk = 0, lowlen = 0;
  bit e_od = 0, e_unk = 0, e_rdy = 0;

  function automatic int kind_of(int len, bit od);
    if (len >= 480) return 3;
    if (!od) return 0;
    if (len > 80) return 2;
    if (len >= 48) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit ln, up, nb;
    int k, lim;
    if (!rst_n) begin
      h1 = 1; h2 = 1; hprev = 1; ph = 0; tk = 0; lowlen = 0;
      e_od = 0; e_unk = 0; e_rdy = 0;
    end else begin
      nb = ~(m_low | (ph == 2));
      ln = h2;
      up = ln && !hprev;
      e_rdy = 0;
      if (ph == 0) begin
        if (up) begin
          k = kind_of(lowlen, e_od);
          lowlen = 0;
          if (k != 0) begin
            if (k == 3) begin e_od = 0; e_unk = 0; end
            if (k == 2) begin e_od = 0; e_unk = 1; end
            if (k == 1) e_unk = 0;
            ph = 1; tk = 0;
          end else if (od_req) e_od = 1;
        end else begin
          if (!ln && tick_us && lowlen < 1023) lowlen++;
          if (od_req) e_od = 1;
        end
      end else begin
        lowlen = 0;
        if (ph == 1) lim = e_od ? 3 : 30;
        else if (ph == 2) lim = e_od ? 12 : 120;
        else lim = e_od ? 2 : 5;
        if (ph == 1 && !ln) begin
          ph = 0; tk = 0;
        end else if (tick_us) begin
          if (tk == lim - 1) begin
            tk = 0;
            if (ph == 3) begin ph = 0; e_rdy = 1; end
            else ph = ph + 1;
          end else tk++;
        end
      end
      hprev = ln; h2 = h1; h1 = nb;
    end
  end

  // per-clock comparison (R7 drive, R8 ready, R2-R4 speed and flag)
  always @(negedge clk) begin
    if (model_on) begin
      chk(pull_low == (ph == 2), "R7 model pull_low", pull_low, ph == 2);
      chk(slot_ready == e_rdy, "R8 model slot_ready", slot_ready, e_rdy);
      chk(od_mode == e_od, "R3 model od_mode", od_mode, e_od);
      chk(speed_unknown == e_unk, "R4 model speed_unknown", speed_unknown, e_unk);
    end
    if (watch && pull_low) watch_pulls++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic low_ticks(input int n);
    do @(posedge clk); while (tick_us !== 1'b1);
    @(negedge clk);
    m_low = 1'b1;
    repeat (4 * n) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic follow(input int lim, output int pw, output bit rdy);
    pw = 0; rdy = 0;
    for (int i = 0; i < lim && !rdy; i++) begin
      @(negedge clk);
      if (pull_low) pw++;
      if (slot_ready) rdy = 1;
    end
  endtask

  task automatic do_reset(input int n, input int exp_pw, input string tag);
    int pw; bit rdy;
    low_ticks(n);
    follow(3000, pw, rdy);
    chk(pw == exp_pw, {tag, " presence width"}, pw, exp_pw);
    chk(rdy == 1, "R8 ready after presence", rdy, 1);
  endtask

  task automatic no_reset(input int n, input string tag);
    int pw; bit rdy;
    low_ticks(n);
    follow(800, pw, rdy);
    chk(pw == 0 && !rdy, {tag, " no response"}, pw, 0);
  endtask

  task automatic pulse_od;
    @(negedge clk); od_req = 1'b1;
    @(negedge clk); od_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int pw; bit rdy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pull_low, od_mode, speed_unknown, slot_ready} == 4'b0, "R1 reset state",
        {pull_low, od_mode, speed_unknown, slot_ready}, 0);
    model_on = 1'b1;

    do_reset(500, 480, "R6 std");                       // R2
    chk(!od_mode && !speed_unknown, "R2 long reset std", od_mode, 0);

    pulse_od; @(negedge clk);
    chk(od_mode == 1, "R10 od_req idle", od_mode, 1);

    do_reset(60, 48, "R6 od");
    chk(od_mode && !speed_unknown, "R3 short reset keeps od", od_mode, 1);

    no_reset(20, "R5 od slot");
    no_reset(47, "R5 od 47");
    chk(od_mode == 1, "R5 od unchanged", od_mode, 1);

    do_reset(200, 480, "R4 std after mid band");
    chk(!od_mode && speed_unknown, "R4 mid band flag", speed_unknown, 1);

    pulse_od; @(negedge clk);
    chk(od_mode && speed_unknown, "R10 flag kept on od_req", speed_unknown, 1);
    do_reset(48, 48, "R3 edge 48");
    chk(od_mode && !speed_unknown, "R3 edge 48 keeps od", od_mode, 1);
    do_reset(80, 48, "R3 edge 80");
    chk(od_mode == 1, "R3 edge 80 keeps od", od_mode, 1);
    do_reset(81, 480, "R4 edge 81");
    chk(!od_mode && speed_unknown, "R4 edge 81 flag", speed_unknown, 1);

    no_reset(479, "R5 std 479");
    chk(speed_unknown == 1, "R5 flag unchanged by 479", speed_unknown, 1);
    do_reset(480, 480, "R2 edge 480");
    chk(!speed_unknown && !od_mode, "R2 edge 480 clears flag", speed_unknown, 0);

    // R9: line pulled low again during presence delay
    low_ticks(500);
    watch_pulls = 0; watch = 1'b1;
    repeat (10) @(negedge clk);
    low_ticks(500);
    watch = 1'b0;
    chk(watch_pulls == 0, "R9 presence cancelled", watch_pulls, 0);
    follow(3000, pw, rdy);
    chk(pw == 480 && rdy, "R9 presence after restart", pw, 480);

    // R10: od_req during sequence ignored
    low_ticks(500);
    repeat (20) @(negedge clk);
    pulse_od;
    follow(3000, pw, rdy);
    chk(rdy && !od_mode, "R10 od_req ignored when busy", od_mode, 0);

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule